// File: doc/BRIEF.md
# Debug abstract command controller

This block is the register-side front end of a processor debug module. A debug host reaches it through a narrow request port that carries a 7-bit register address, 32-bit write data, a write flag and a valid/ready handshake. Every accepted request returns a response one cycle later with read data and an error flag for unmapped addresses. The block holds a control word, an abstract status word, the last command word and a small bank of data words.

When a register-access command arrives, the block checks it against a fixed order of rules. The rules cover command type, register number, the halt state of the selected hart and access size. A command that fails leaves an error code behind. A command that passes raises busy and hands the work to a separate instruction patcher through a start pulse. The patcher's done pulse clears busy again.

The error code is sticky, so every later command is dropped until the host clears it. Touching a data word while busy is itself recorded as an error. A data word can also be set to launch the stored command again each time it is accessed. The block also drives per-hart halt and resume requests from the control word.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: After reset, or after a control write with bit 0 (active) at 0, halt_req is all zero, the control word reads active=0, hart select [7:4]=0, authenticated bit 12 = 1, version [19:16] = 1. The status word reads error [10:8] = 0, auto-execute [23:16] = 0 and data count [3:0] = NDATA. Busy is left as it was.
- R2: A command (address 0x13) whose bits [31:24] are nonzero sets the error code to 2 (not supported) and does not start.
- R3: A register number in bits [15:0] outside 0x1000..0x101F sets error 2. A size code in bits [22:20] other than 2 or 3 also sets error 2. An accepted command presents patch_regidx = regno - 0x1000, patch_write = bit 16, and patch_wide = 1 for size 3. The checks run in this order: type, register number, halt state, size.
- R4: A command with valid type and register number, sent while the selected hart is not halted or does not exist, sets error 4 (halt/resume).
- R5: An accepted command makes patch_start high for exactly one cycle and sets busy (status bit 12) on the same edge. Busy stays set until patch_done is seen.
- R6: A command issued while busy, with the error code at 0, sets the error code to 1 (busy) and does not start.
- R7: While the error code is nonzero, commands are ignored: no start, and the error code is unchanged.
- R8: A status write (address 0x11) loads the auto-execute bits from [23:16]. It clears the error code only when written bits [10:8] are 0.
- R9: Data word i (addresses 0x04 + i) is readable and writable. Reading or writing it while busy, with the error code at 0, sets the error code to 1.
- R10: If auto-execute bit i is set, a read or write of data word i re-issues the stored command under R2 to R7.
- R11: A control write with active=1 loads hart select from [7:4] and sets the selected hart's halt request from bit 1. Control read returns that hart's halt request in bit 1 and the hart status in [9:8]: 0 running, 1 halted, 2 nonexistent.
- R12: A control write with active=1 and bit 2 set pulses resume_req for the selected existing hart for one cycle.
- R13: The command register reads 0, and the access register (0x12) reads PROGSIZE in [28:24]. Any other unmapped address sets rsp_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped address |
| hart_halted | input | NHARTS | Per-hart halted state |
| halt_req | output | NHARTS | Per-hart halt request |
| resume_req | output | NHARTS | Per-hart resume pulse |
| patch_start | output | 1 | Start pulse to the patcher |
| patch_regidx | output | 5 | General register index |
| patch_write | output | 1 | Command writes the register |
| patch_wide | output | 1 | 64-bit access |
| patch_done | input | 1 | Patcher finished |

## Verification
A stuck or wrongly cleared error code shows up in two ways. The status read that follows the request reports the wrong code. The next good command also gets a missing or spurious patch_start, one cycle after the request. A lost busy bit lets a second command start while the patcher is still running, which is visible on patch_start at once. An error in the validation order surfaces as the wrong code on the first status read after a command that breaks two rules. Wrong hart bookkeeping shows on halt_req the cycle after the control write, and in the status field of the next control read.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
    localparam int AW = 7;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_BUSY   = 3'd1,
        ERR_NOTSUP = 3'd2,
        ERR_EXCEPT = 3'd3,
        ERR_HALT   = 3'd4
    } dbg_err_e;

    localparam logic [AW-1:0] A_DATA   = 7'h04;
    localparam logic [AW-1:0] A_CTRL   = 7'h10;
    localparam logic [AW-1:0] A_STAT   = 7'h11;
    localparam logic [AW-1:0] A_ACCESS = 7'h12;
    localparam logic [AW-1:0] A_CMD    = 7'h13;

    localparam logic [15:0] GPR_BASE = 16'h1000;
    localparam int          NUM_GPR  = 32;
endpackage

// File: rtl/dbg_cmd_check.sv
module dbg_cmd_check
    import dbg_cmd_pkg::*;
(
    input  logic [31:0] cmd,
    input  logic        sel_halted,
    output logic        ok,
    output dbg_err_e    code,
    output logic [4:0]  regidx,
    output logic        wr,
    output logic        wide
);
    localparam logic [15:0] GPR_END = GPR_BASE + 16'(NUM_GPR);

    logic [15:0] regno;
    logic [2:0]  size;

    assign regno  = cmd[15:0];
    assign size   = cmd[22:20];
    assign wr     = cmd[16];
    assign wide   = (size == 3'd3);
    assign regidx = 5'(regno - GPR_BASE);

    always_comb begin
        ok   = 1'b0;
        code = ERR_NONE;
        if (cmd[31:24] != 8'd0) begin
            code = ERR_NOTSUP;
        end else if (regno < GPR_BASE || regno >= GPR_END) begin
            code = ERR_NOTSUP;
        end else if (!sel_halted) begin
            code = ERR_HALT;
        end else if (size != 3'd2 && size != 3'd3) begin
            code = ERR_NOTSUP;
        end else begin
            ok = 1'b1;
        end
    end
endmodule

// File: rtl/dbg_cmd_rdmux.sv
module dbg_cmd_rdmux
    import dbg_cmd_pkg::*;
#(
    parameter int NDATA    = 4,
    parameter int HSEL_W   = 4,
    parameter int PROGSIZE = 8
) (
    input  logic [AW-1:0]             addr,
    input  logic                      active,
    input  logic [HSEL_W-1:0]         hsel,
    input  logic                      halt_sel,
    input  logic [1:0]                hstat,
    input  logic                      busy,
    input  logic [2:0]                err,
    input  logic [7:0]                autox,
    input  logic [NDATA-1:0][31:0]    data,
    output logic [31:0]               rdata,
    output logic                      hit
);
    localparam int          IDX_W    = (NDATA > 1) ? $clog2(NDATA) : 1;
    localparam logic [AW-1:0] DATA_END = AW'(int'(A_DATA) + NDATA);

    logic [IDX_W-1:0] didx;
    assign didx = IDX_W'(addr - A_DATA);

    always_comb begin
        rdata = 32'd0;
        hit   = 1'b1;
        if (addr >= A_DATA && addr < DATA_END) begin
            rdata = data[didx];
        end else begin
            case (addr)
                A_CTRL: begin
                    rdata[0]          = active;
                    rdata[1]          = halt_sel;
                    rdata[4+:HSEL_W]  = hsel;
                    rdata[9:8]        = hstat;
                    rdata[12]         = 1'b1;
                    rdata[19:16]      = 4'd1;
                end
                A_STAT: begin
                    rdata[3:0]   = 4'(NDATA);
                    rdata[10:8]  = err;
                    rdata[12]    = busy;
                    rdata[23:16] = autox;
                end
                A_ACCESS: rdata[28:24] = 5'(PROGSIZE);
                A_CMD:    rdata = 32'd0;
                default:  hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
    import dbg_cmd_pkg::*;
#(
    parameter int NDATA    = 4,
    parameter int NHARTS   = 2,
    parameter int HSEL_W   = 4,
    parameter int PROGSIZE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [NHARTS-1:0] hart_halted,
    output logic [NHARTS-1:0] halt_req,
    output logic [NHARTS-1:0] resume_req,
    output logic              patch_start,
    output logic [4:0]        patch_regidx,
    output logic              patch_write,
    output logic              patch_wide,
    input  logic              patch_done
);
    localparam int            IDX_W    = (NDATA > 1) ? $clog2(NDATA) : 1;
    localparam logic [AW-1:0] DATA_END = AW'(int'(A_DATA) + NDATA);

    typedef struct packed {
        logic                   active;
        logic [HSEL_W-1:0]      hsel;
        logic [NHARTS-1:0]      halt;
        logic [NHARTS-1:0]      resume;
        logic                   busy;
        dbg_err_e               err;
        logic [7:0]             autox;
        logic [31:0]            cmd;
        logic [NDATA-1:0][31:0] data;
        logic                   start;
        logic [4:0]             regidx;
        logic                   wr;
        logic                   wide;
        logic                   rsp_v;
        logic                   rsp_e;
        logic [31:0]            rdata;
    } state_t;

    state_t st_d, st_q;

    // Selected-hart view
    logic       sel_exists, sel_halted, sel_haltreq;
    logic [1:0] sel_stat;
    always_comb begin
        sel_exists  = (int'(st_q.hsel) < NHARTS);
        sel_halted  = 1'b0;
        sel_haltreq = 1'b0;
        for (int h = 0; h < NHARTS; h++) begin
            if (int'(st_q.hsel) == h) begin
                sel_halted  = hart_halted[h];
                sel_haltreq = st_q.halt[h];
            end
        end
        sel_stat = !sel_exists ? 2'd2 : (sel_halted ? 2'd1 : 2'd0);
    end

    logic        is_data, is_cmd_wr;
    logic [IDX_W-1:0] didx;
    assign is_data   = (req_addr >= A_DATA) && (req_addr < DATA_END);
    assign is_cmd_wr = req_valid && req_write && (req_addr == A_CMD);
    assign didx      = IDX_W'(req_addr - A_DATA);

    logic        chk_ok, chk_wr, chk_wide;
    dbg_err_e    chk_code;
    logic [4:0]  chk_idx;

    dbg_cmd_check u_check (
        .cmd        (is_cmd_wr ? req_wdata : st_q.cmd),
        .sel_halted (sel_halted),
        .ok         (chk_ok),
        .code       (chk_code),
        .regidx     (chk_idx),
        .wr         (chk_wr),
        .wide       (chk_wide)
    );

    logic [31:0] rd_data;
    logic        rd_hit;

    dbg_cmd_rdmux #(
        .NDATA    (NDATA),
        .HSEL_W   (HSEL_W),
        .PROGSIZE (PROGSIZE)
    ) u_rdmux (
        .addr     (req_addr),
        .active   (st_q.active),
        .hsel     (st_q.hsel),
        .halt_sel (sel_haltreq),
        .hstat    (sel_stat),
        .busy     (st_q.busy),
        .err      (st_q.err),
        .autox    (st_q.autox),
        .data     (st_q.data),
        .rdata    (rd_data),
        .hit      (rd_hit)
    );

    always_comb begin
        logic                go;
        logic [HSEL_W-1:0]   nsel;
        st_d        = st_q;
        st_d.start  = 1'b0;
        st_d.resume = '0;
        st_d.rsp_v  = 1'b0;
        st_d.rsp_e  = 1'b0;
        go          = 1'b0;
        nsel        = req_wdata[4+:HSEL_W];

        if (patch_done) st_d.busy = 1'b0;

        if (req_valid) begin
            st_d.rsp_v = 1'b1;
            st_d.rdata = rd_data;
            st_d.rsp_e = !rd_hit;
            if (is_data) begin
                if (req_write) st_d.data[didx] = req_wdata;
                if (st_d.busy && st_d.err == ERR_NONE) st_d.err = ERR_BUSY;
                go = st_q.autox[didx];
            end else if (req_write) begin
                case (req_addr)
                    A_CTRL: begin
                        st_d.active = req_wdata[0];
                        if (req_wdata[0]) begin
                            st_d.hsel = nsel;
                            for (int h = 0; h < NHARTS; h++) begin
                                if (int'(nsel) == h) begin
                                    st_d.halt[h]   = req_wdata[1];
                                    st_d.resume[h] = req_wdata[2];
                                end
                            end
                        end else begin
                            st_d.hsel  = '0;
                            st_d.halt  = '0;
                            st_d.err   = ERR_NONE;
                            st_d.autox = '0;
                        end
                    end
                    A_STAT: begin
                        st_d.autox = req_wdata[23:16];
                        if (req_wdata[10:8] == 3'd0) st_d.err = ERR_NONE;
                    end
                    A_CMD: begin
                        st_d.cmd = req_wdata;
                        go       = 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        if (go && st_d.err == ERR_NONE) begin
            if (st_d.busy) begin
                st_d.err = ERR_BUSY;
            end else if (!chk_ok) begin
                st_d.err = chk_code;
            end else begin
                st_d.busy   = 1'b1;
                st_d.start  = 1'b1;
                st_d.regidx = chk_idx;
                st_d.wr     = chk_wr;
                st_d.wide   = chk_wide;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic     busy_q;
    dbg_err_e err_q;
    assign busy_q = st_q.busy;
    assign err_q  = st_q.err;

    assign req_ready    = 1'b1;
    assign rsp_valid    = st_q.rsp_v;
    assign rsp_rdata    = st_q.rdata;
    assign rsp_err      = st_q.rsp_e;
    assign halt_req     = st_q.halt;
    assign resume_req   = st_q.resume;
    assign patch_start  = st_q.start;
    assign patch_regidx = st_q.regidx;
    assign patch_write  = st_q.wr;
    assign patch_wide   = st_q.wide;
endmodule

// File: rtl/dbg_cmd_ctrl_sva.sv
module dbg_cmd_ctrl_sva
    import dbg_cmd_pkg::*;
#(
    parameter int NHARTS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [AW-1:0]     req_addr,
    input logic [31:0]       req_wdata,
    input logic              patch_start,
    input logic              patch_done,
    input logic [NHARTS-1:0] resume_req,
    input logic              busy_q,
    input logic [2:0]        err_q
);
    logic clear_req;
    assign clear_req = req_valid && req_write &&
                       ((req_addr == A_STAT && req_wdata[10:8] == 3'd0) ||
                        (req_addr == A_CTRL && !req_wdata[0]));

    assert_start_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        patch_start |-> busy_q);

    assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !patch_done) |=> busy_q);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != 3'd0 && !clear_req) |=> $stable(err_q));

    assert_no_start_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != 3'd0) |=> !patch_start);

    assert_err_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_q <= 3'd4);

    assert_resume_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resume_req));
endmodule

bind dbg_cmd_ctrl dbg_cmd_ctrl_sva #(.NHARTS(NHARTS)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .patch_start (patch_start),
    .patch_done  (patch_done),
    .resume_req  (resume_req),
    .busy_q      (busy_q),
    .err_q       (err_q)
);

// File: tb/tb_dbg_cmd_ctrl.sv
module tb_dbg_cmd_ctrl;
    localparam int NDATA = 4, NHARTS = 2, PROGSIZE = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [NHARTS-1:0] hart_halted = '0, halt_req, resume_req;
    logic        patch_start, patch_write, patch_wide, patch_done = 1'b0;
    logic [4:0]  patch_regidx;

    int total = 0, bad = 0;
    logic        s_start, s_write, s_wide, s_err;
    logic [4:0]  s_idx;
    logic [31:0] s_data;
    logic [NHARTS-1:0] s_resume;

    always #5 clk = ~clk;

    dbg_cmd_ctrl #(.NDATA(NDATA), .NHARTS(NHARTS), .PROGSIZE(PROGSIZE)) dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
        .rsp_valid, .rsp_rdata, .rsp_err, .hart_halted, .halt_req, .resume_req,
        .patch_start, .patch_regidx, .patch_write, .patch_wide, .patch_done
    );

    localparam logic [6:0] CTRL = 7'h10, STAT = 7'h11, ACC = 7'h12, CMD = 7'h13, DAT = 7'h04;

    function automatic logic [31:0] mk_cmd(input logic [7:0] ty, input logic [2:0] sz,
                                           input logic wr, input logic [15:0] rn);
        return {ty, 1'b0, sz, 3'b0, wr, rn};
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic act, input logic hr,
                                            input logic rs, input logic [3:0] sel);
        return {24'd0, sel, 1'b0, rs, hr, act};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        s_start = patch_start; s_idx = patch_regidx; s_write = patch_write;
        s_wide = patch_wide; s_data = rsp_rdata; s_err = rsp_err; s_resume = resume_req;
    endtask

    task automatic read_err(output logic [31:0] e);
        access(1'b0, STAT, 32'd0);
        e = {29'd0, s_data[10:8]};
    endtask

    task automatic clear_err();
        access(1'b1, STAT, 32'd0);
    endtask

    task automatic pulse_done();
        @(negedge clk); patch_done = 1'b1;
        @(negedge clk); patch_done = 1'b0;
    endtask

    task automatic t_reset();
        access(1'b0, CTRL, 32'd0);
        check("R1", "ctrl after reset", s_data & 32'h000F_13F3, 32'h0001_1000);
        access(1'b0, STAT, 32'd0);
        check("R1", "stat after reset", s_data, 32'(NDATA));
        check("R1", "halt_req after reset", 32'(halt_req), 32'd0);
    endtask

    task automatic t_not_halted();
        logic [31:0] e;
        hart_halted = 2'b00;
        access(1'b1, CTRL, mk_ctrl(1, 0, 0, 4'd0));
        access(1'b1, CMD, mk_cmd(8'd0, 3'd2, 1'b0, 16'h1001));
        check("R4", "no start", 32'(s_start), 32'd0);
        read_err(e);
        check("R4", "halt error", e, 32'd4);
        access(1'b1, STAT, 32'h0000_0300);
        read_err(e);
        check("R8", "nonzero field keeps error", e, 32'd4);
        access(1'b1, STAT, 32'h00A5_0000);
        access(1'b0, STAT, 32'd0);
        check("R8", "autox loaded, error cleared", s_data & 32'h00FF_0700, 32'h00A5_0000);
        access(1'b1, STAT, 32'd0);
    endtask

    task automatic t_unsup();
        logic [31:0] e;
        logic [31:0] cmds [4];
        cmds[0] = mk_cmd(8'd1, 3'd2, 1'b0, 16'h1000);
        cmds[1] = mk_cmd(8'd0, 3'd2, 1'b0, 16'h0FFF);
        cmds[2] = mk_cmd(8'd0, 3'd2, 1'b0, 16'h1020);
        cmds[3] = mk_cmd(8'd0, 3'd4, 1'b0, 16'h1000);
        hart_halted = 2'b01;
        for (int i = 0; i < 4; i++) begin
            access(1'b1, CMD, cmds[i]);
            check(i == 0 ? "R2" : "R3", "unsupported no start", 32'(s_start), 32'd0);
            read_err(e);
            check(i == 0 ? "R2" : "R3", "unsupported code", e, 32'd2);
            clear_err();
        end
        hart_halted = 2'b00;
        access(1'b1, CMD, mk_cmd(8'd0, 3'd4, 1'b0, 16'h1000));
        read_err(e);
        check("R3", "halt checked before size", e, 32'd4);
        clear_err();
        hart_halted = 2'b01;
    endtask

    task automatic t_start_busy();
        logic [31:0] e;
        access(1'b1, CMD, mk_cmd(8'd0, 3'd2, 1'b1, 16'h101F));
        check("R5", "start pulse", 32'(s_start), 32'd1);
        check("R3", "regidx", 32'(s_idx), 32'd31);
        check("R3", "write/wide", {30'd0, s_write, s_wide}, 32'd2);
        access(1'b0, STAT, 32'd0);
        check("R5", "busy set, start one cycle", {s_data[12], 30'd0, patch_start}, 32'h8000_0000);
        access(1'b1, CMD, mk_cmd(8'd0, 3'd2, 1'b1, 16'h1001));
        check("R6", "no start while busy", 32'(s_start), 32'd0);
        read_err(e);
        check("R6", "busy error", e, 32'd1);
        clear_err();
        access(1'b1, DAT + 7'd2, 32'h1234_5678);
        read_err(e);
        check("R9", "data write while busy", e, 32'd1);
        clear_err();
        access(1'b0, DAT + 7'd2, 32'd0);
        read_err(e);
        check("R9", "data read while busy", e, 32'd1);
        clear_err();
        pulse_done();
        access(1'b0, STAT, 32'd0);
        check("R5", "busy cleared by done", 32'(s_data[12]), 32'd0);
    endtask

    task automatic t_sticky();
        logic [31:0] e;
        access(1'b1, CMD, mk_cmd(8'd3, 3'd2, 1'b0, 16'h1000));
        access(1'b1, CMD, mk_cmd(8'd0, 3'd2, 1'b0, 16'h1000));
        check("R7", "ignored while error", 32'(s_start), 32'd0);
        read_err(e);
        check("R7", "error unchanged", e, 32'd2);
        clear_err();
    endtask

    task automatic t_data();
        logic [31:0] e;
        access(1'b1, DAT, 32'hDEAD_BEEF);
        access(1'b0, DAT, 32'd0);
        check("R9", "data readback", s_data, 32'hDEAD_BEEF);
        access(1'b0, DAT + 7'd2, 32'd0);
        check("R9", "data2 kept", s_data, 32'h1234_5678);
        read_err(e);
        check("R9", "idle access no error", e, 32'd0);
    endtask

    task automatic t_autoexec();
        access(1'b1, STAT, 32'h0002_0000);
        access(1'b1, CMD, mk_cmd(8'd0, 3'd3, 1'b0, 16'h1003));
        check("R5", "64-bit start", 32'(s_start), 32'd1);
        pulse_done();
        access(1'b1, DAT + 7'd1, 32'h0000_0055);
        check("R10", "write data1 reissues", {27'd0, s_start, s_wide, s_idx[2:0]}, 32'h1B);
        pulse_done();
        access(1'b0, DAT + 7'd1, 32'd0);
        check("R10", "read data1 reissues", 32'(s_start), 32'd1);
        pulse_done();
        access(1'b1, DAT, 32'h1);
        check("R10", "bit clear no reissue", 32'(s_start), 32'd0);
        access(1'b1, STAT, 32'd0);
    endtask

    task automatic t_ctrl();
        hart_halted = 2'b10;
        access(1'b1, CTRL, mk_ctrl(1, 1, 0, 4'd1));
        check("R11", "halt_req hart1", 32'(halt_req), 32'd2);
        access(1'b0, CTRL, 32'd0);
        check("R11", "ctrl halted", s_data & 32'h3F3, 32'h113);
        hart_halted = 2'b00;
        access(1'b0, CTRL, 32'd0);
        check("R11", "ctrl running", 32'(s_data[9:8]), 32'd0);
        access(1'b1, CTRL, mk_ctrl(1, 0, 0, 4'd5));
        access(1'b0, CTRL, 32'd0);
        check("R11", "ctrl nonexistent", s_data & 32'h3F2, 32'h250);
        check("R11", "other hart keeps halt", 32'(halt_req), 32'd2);
        access(1'b1, CTRL, 32'd0);
        check("R1", "deactivate drops halt", 32'(halt_req), 32'd0);
        access(1'b0, CTRL, 32'd0);
        check("R1", "deactivated ctrl", s_data & 32'h000F_13F3, 32'h0001_1000);
    endtask

    task automatic t_resume();
        access(1'b1, CTRL, mk_ctrl(1, 0, 1, 4'd0));
        check("R12", "resume pulse", 32'(s_resume), 32'd1);
        @(negedge clk);
        check("R12", "resume one cycle", 32'(resume_req), 32'd0);
    endtask

    task automatic t_misc();
        access(1'b0, CMD, 32'd0);
        check("R13", "cmd reads zero", s_data, 32'd0);
        access(1'b0, ACC, 32'd0);
        check("R13", "progsize", s_data, 32'(PROGSIZE) << 24);
        check("R13", "mapped no err", 32'(s_err), 32'd0);
        access(1'b0, 7'h3F, 32'd0);
        check("R13", "unmapped err", 32'(s_err), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_not_halted();
        t_unsup();
        t_start_busy();
        t_sticky();
        t_data();
        t_autoexec();
        t_ctrl();
        t_resume();
        t_misc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule